// File: doc/BRIEF.md
# Confidence-Gated Stream Buffer Allocator and Resource Scheduler

This block sits beside a bank of prefetch stream buffers and makes two decisions for them. First, when a load misses, it decides whether that load deserves a stream buffer. By default a load must have a good record: a small saturating confidence counter is kept per load, selected by a hash of the load's PC word address. The counter rises when one of its prefetches turns out useful and falls when one is thrown away unused. A second, selectable filter instead grants a buffer to a load only on its second miss. When a buffer is granted, the block also names which buffer gets replaced: the one that has been least productive.

Second, every cycle it picks which requesting buffer may use the shared address predictor and the memory port. Each buffer carries a small saturating rank counter. A hit raises the counter, and a periodic decay lowers all counters. In ranked mode the highest-ranked requester wins. A round-robin mode is provided for comparison and gives each requester an equal turn. All decisions are combinational from the current state and the current inputs. Counter updates take effect at the next clock edge. The buffer storage itself lives elsewhere.

Top module: `prefetch_alloc_sched`

## Requirements
- R1: The confidence table has 2^TBL_W entries of 2-bit saturating counters, reset to 2. The entry index is the fold of the PC word: index bit k is the XOR of every PC bit i with i mod TBL_W equal to k. A useful event adds 1, saturating at 3. A useless event subtracts 1, saturating at 0. Both events on the same entry in one cycle leave it unchanged.
- R2: With modeTwoMiss low, allocValid is high in the same cycle as missValid exactly when the missing load's confidence entry is 2 or more.
- R3: With modeTwoMiss high, each table index has a seen bit, cleared by reset. A miss whose seen bit is clear sets it and does not allocate. A miss whose seen bit is set allocates and clears it. Seen bits change only while modeTwoMiss is high.
- R4: allocValid is never high without missValid.
- R5: allocBuf names the buffer with the lowest rank counter, and the lowest index wins a tie. On an allocation, that buffer's counter is set to PRI_INIT (3) at the next edge, overriding any hit or decay.
- R6: Rank counters are 3-bit, reset to 0, and rise by 1 on hitValid for buffer hitBuf, saturating at 7.
- R7: A free-running counter starts at zero when reset is released and signals a decay every DECAY_PERIOD cycles. The first decay falls on the edge that ends the DECAY_PERIOD-th cycle after release. On that edge every nonzero counter drops by 1. A buffer that is hit on the same edge keeps its value.
- R8: With modeRoundRobin low, grantVec is one-hot on the requesting buffer with the highest rank, and the lowest index wins a tie. grantVec is zero when reqVec is zero. Bit b of grantVec and of reqVec stands for buffer b.
- R9: With modeRoundRobin high, the grant goes to the first requesting buffer at or after the turn pointer, wrapping around. The pointer resets to 0. After any grant, in either mode, the pointer becomes the granted index plus 1, modulo NUM_BUF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeRoundRobin | input | 1 | 1: round-robin grant, 0: ranked grant |
| modeTwoMiss | input | 1 | 1: second-miss filter, 0: confidence filter |
| missValid | input | 1 | A load missed this cycle |
| missPcWord | input | PC_W | PC word address of the missing load |
| usefulValid | input | 1 | A prefetch was consumed |
| usefulPcWord | input | PC_W | PC word of the load that issued it |
| uselessValid | input | 1 | A prefetch was evicted unused |
| uselessPcWord | input | PC_W | PC word of the load that issued it |
| hitValid | input | 1 | A load hit in a stream buffer |
| hitBuf | input | IDX_W | Buffer that was hit |
| reqVec | input | NUM_BUF | Per-buffer request for predictor and memory port |
| allocValid | output | 1 | The missing load is granted a buffer |
| allocBuf | output | IDX_W | Buffer to replace |
| grantVec | output | NUM_BUF | One-hot resource grant |

## Verification
A wrong confidence entry shows as an allocValid that differs in the very cycle the affected load misses. It can stay hidden until that load misses again. A wrong rank counter shows in the next cycle's allocBuf, or in the next ranked grant among conflicting requesters. A missed or extra decay shifts ranks only when they are compared. A stale turn pointer changes the round-robin winner on the next grant that has more than one requester. The bench runs a cycle model alongside the design and compares all three outputs every cycle, so such a divergence is reported in the first cycle it reaches a port.

// File: rtl/pas_pkg.sv
package pas_pkg;
  typedef struct packed {
    logic allocGo;
    logic decayTick;
    logic hitGo;
  } strobe_t;
endpackage

// File: rtl/pas_ctrl.sv
module pas_ctrl import pas_pkg::*; #(
  parameter int PC_W         = 30,
  parameter int TBL_W        = 4,
  parameter int ACC_W        = 2,
  parameter int ACC_INIT     = 2,
  parameter int ACC_MIN      = 2,
  parameter int DECAY_PERIOD = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            modeTwoMiss,
  input  logic            missValid,
  input  logic [PC_W-1:0] missPcWord,
  input  logic            usefulValid,
  input  logic [PC_W-1:0] usefulPcWord,
  input  logic            uselessValid,
  input  logic [PC_W-1:0] uselessPcWord,
  input  logic            hitValid,
  output logic            allocValid,
  output strobe_t         strobes
);
  localparam int TBL     = 1 << TBL_W;
  localparam int ACC_MAX = (1 << ACC_W) - 1;
  localparam int DEC_W   = $clog2(DECAY_PERIOD);

  function automatic logic [TBL_W-1:0] foldPc(input logic [PC_W-1:0] pc);
    logic [TBL_W-1:0] h;
    h = '0;
    for (int i = 0; i < PC_W; i++) h[i % TBL_W] = h[i % TBL_W] ^ pc[i];
    return h;
  endfunction

  logic [TBL_W-1:0] missIdx, usefulIdx, uselessIdx;
  assign missIdx    = foldPc(missPcWord);
  assign usefulIdx  = foldPc(usefulPcWord);
  assign uselessIdx = foldPc(uselessPcWord);

  logic [ACC_W-1:0] accTbl [TBL];
  logic [TBL-1:0]   seenTbl;

  for (genvar e = 0; e < TBL; e++) begin : g_entry
    logic incE, decE;
    assign incE = usefulValid  && (usefulIdx  == TBL_W'(e));
    assign decE = uselessValid && (uselessIdx == TBL_W'(e));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        accTbl[e] <= ACC_W'(ACC_INIT);
      end else if (incE && !decE && accTbl[e] != ACC_W'(ACC_MAX)) begin
        accTbl[e] <= accTbl[e] + 1'b1;
      end else if (decE && !incE && accTbl[e] != '0) begin
        accTbl[e] <= accTbl[e] - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) seenTbl[e] <= 1'b0;
      else if (modeTwoMiss && missValid && missIdx == TBL_W'(e)) seenTbl[e] <= ~seenTbl[e];
    end
  end

  always_comb begin
    if (!missValid)       allocValid = 1'b0;
    else if (modeTwoMiss) allocValid = seenTbl[missIdx];
    else                  allocValid = (accTbl[missIdx] >= ACC_W'(ACC_MIN));
  end

  logic [DEC_W-1:0] decayCnt;
  logic             tick;
  assign tick = (decayCnt == DEC_W'(DECAY_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rstN)     decayCnt <= '0;
    else if (tick) decayCnt <= '0;
    else           decayCnt <= decayCnt + 1'b1;
  end

  assign strobes.allocGo   = allocValid;
  assign strobes.decayTick = tick;
  assign strobes.hitGo     = hitValid;

  // R1: confidence saturates at the top
  a_r1_acc_ceiling: assert property (@(posedge clk) disable iff (!rstN)
    (usefulValid && !(uselessValid && uselessIdx == usefulIdx) &&
     accTbl[usefulIdx] == ACC_W'(ACC_MAX))
    |=> accTbl[$past(usefulIdx)] == ACC_W'(ACC_MAX));

  // R1: confidence saturates at zero
  a_r1_acc_floor: assert property (@(posedge clk) disable iff (!rstN)
    (uselessValid && !(usefulValid && uselessIdx == usefulIdx) && accTbl[uselessIdx] == '0)
    |=> accTbl[$past(uselessIdx)] == '0);

  // R3: a second-miss allocation consumes the seen bit
  a_r3_seen_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (modeTwoMiss && allocValid) |=> !seenTbl[$past(missIdx)]);

  // R4: no allocation without a miss
  a_r4_alloc_needs_miss: assert property (@(posedge clk) disable iff (!rstN)
    allocValid |-> missValid);
endmodule

// File: rtl/pas_dp.sv
module pas_dp import pas_pkg::*; #(
  parameter int NUM_BUF  = 4,
  parameter int PRI_W    = 3,
  parameter int PRI_INIT = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       modeRoundRobin,
  input  strobe_t                    strobes,
  input  logic [$clog2(NUM_BUF)-1:0] hitBuf,
  input  logic [NUM_BUF-1:0]         reqVec,
  output logic [$clog2(NUM_BUF)-1:0] allocBuf,
  output logic [NUM_BUF-1:0]         grantVec
);
  localparam int IDX_W   = $clog2(NUM_BUF);
  localparam int PRI_MAX = (1 << PRI_W) - 1;

  logic [PRI_W-1:0] prio [NUM_BUF];
  logic [IDX_W-1:0] rrPtr;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    logic incB, decB, allocB;
    assign allocB = strobes.allocGo && (allocBuf == IDX_W'(b));
    assign incB   = strobes.hitGo   && (hitBuf   == IDX_W'(b));
    assign decB   = strobes.decayTick;

    always_ff @(posedge clk) begin
      if (!rstN)                                                prio[b] <= '0;
      else if (allocB)                                          prio[b] <= PRI_W'(PRI_INIT);
      else if (incB && !decB && prio[b] != PRI_W'(PRI_MAX))     prio[b] <= prio[b] + 1'b1;
      else if (decB && !incB && prio[b] != '0)                  prio[b] <= prio[b] - 1'b1;
    end

    // R7: a plain decay lowers a nonzero counter by one
    a_r7_decay_step: assert property (@(posedge clk) disable iff (!rstN)
      (decB && !incB && !allocB && prio[b] != '0) |=> prio[b] == $past(prio[b]) - 1'b1);
  end

  // lowest rank, lowest index on a tie
  always_comb begin
    logic [PRI_W-1:0] low;
    allocBuf = '0;
    low      = prio[0];
    for (int b = 1; b < NUM_BUF; b++) begin
      if (prio[b] < low) begin
        low      = prio[b];
        allocBuf = IDX_W'(b);
      end
    end
  end

  logic [IDX_W-1:0] pWin, rWin, win;
  always_comb begin
    logic             pAny;
    logic [PRI_W-1:0] pBest;
    pWin  = '0;
    pAny  = 1'b0;
    pBest = '0;
    for (int b = 0; b < NUM_BUF; b++) begin
      if (reqVec[b] && (!pAny || prio[b] > pBest)) begin
        pAny  = 1'b1;
        pBest = prio[b];
        pWin  = IDX_W'(b);
      end
    end
  end

  always_comb begin
    logic           rAny;
    logic [IDX_W:0] sum;
    logic [IDX_W-1:0] j;
    rWin = '0;
    rAny = 1'b0;
    for (int k = 0; k < NUM_BUF; k++) begin
      sum = {1'b0, rrPtr} + (IDX_W+1)'(k);
      if (sum >= (IDX_W+1)'(NUM_BUF)) sum = sum - (IDX_W+1)'(NUM_BUF);
      j = sum[IDX_W-1:0];
      if (!rAny && reqVec[j]) begin
        rAny = 1'b1;
        rWin = j;
      end
    end
  end

  assign win = modeRoundRobin ? rWin : pWin;

  always_comb begin
    grantVec = '0;
    if (|reqVec) grantVec[win] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                rrPtr <= '0;
    else if (|reqVec && win == IDX_W'(NUM_BUF - 1)) rrPtr <= '0;
    else if (|reqVec)                         rrPtr <= win + 1'b1;
  end

  // R8: at most one grant, only to a requester
  a_r8_grant_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec) && ((grantVec & ~reqVec) == '0));
  a_r8_grant_when_req: assert property (@(posedge clk) disable iff (!rstN)
    (|reqVec) |-> (|grantVec));
  // R5: allocated buffer restarts at the initial rank
  a_r5_alloc_init: assert property (@(posedge clk) disable iff (!rstN)
    strobes.allocGo |=> prio[$past(allocBuf)] == PRI_W'(PRI_INIT));
  // R6: a hit on a saturated counter keeps it saturated
  a_r6_hit_sat: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.hitGo && !strobes.decayTick && prio[hitBuf] == PRI_W'(PRI_MAX) &&
     !(strobes.allocGo && allocBuf == hitBuf)) |=> prio[$past(hitBuf)] == PRI_W'(PRI_MAX));
  // R9: the buffer at the turn pointer wins when it asks
  a_r9_rr_turn: assert property (@(posedge clk) disable iff (!rstN)
    (modeRoundRobin && reqVec[rrPtr]) |-> grantVec[rrPtr]);
endmodule

// File: rtl/prefetch_alloc_sched.sv
module prefetch_alloc_sched import pas_pkg::*; #(
  parameter int NUM_BUF      = 4,
  parameter int PC_W         = 30,
  parameter int TBL_W        = 4,
  parameter int PRI_W        = 3,
  parameter int PRI_INIT     = 3,
  parameter int DECAY_PERIOD = 64,
  localparam int IDX_W       = $clog2(NUM_BUF)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeRoundRobin,
  input  logic               modeTwoMiss,
  input  logic               missValid,
  input  logic [PC_W-1:0]    missPcWord,
  input  logic               usefulValid,
  input  logic [PC_W-1:0]    usefulPcWord,
  input  logic               uselessValid,
  input  logic [PC_W-1:0]    uselessPcWord,
  input  logic               hitValid,
  input  logic [IDX_W-1:0]   hitBuf,
  input  logic [NUM_BUF-1:0] reqVec,
  output logic               allocValid,
  output logic [IDX_W-1:0]   allocBuf,
  output logic [NUM_BUF-1:0] grantVec
);
  strobe_t strobes;

  pas_ctrl #(
    .PC_W(PC_W), .TBL_W(TBL_W), .ACC_W(2), .ACC_INIT(2), .ACC_MIN(2),
    .DECAY_PERIOD(DECAY_PERIOD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modeTwoMiss(modeTwoMiss),
    .missValid(missValid), .missPcWord(missPcWord),
    .usefulValid(usefulValid), .usefulPcWord(usefulPcWord),
    .uselessValid(uselessValid), .uselessPcWord(uselessPcWord),
    .hitValid(hitValid), .allocValid(allocValid), .strobes(strobes)
  );

  pas_dp #(
    .NUM_BUF(NUM_BUF), .PRI_W(PRI_W), .PRI_INIT(PRI_INIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .modeRoundRobin(modeRoundRobin),
    .strobes(strobes), .hitBuf(hitBuf), .reqVec(reqVec),
    .allocBuf(allocBuf), .grantVec(grantVec)
  );
endmodule

// File: tb/sim_prefetch_alloc_sched.sv
`timescale 1ns/1ps
module sim_prefetch_alloc_sched;
  localparam int NB = 4, PCW = 30, TW = 4, DP = 16, PINIT = 3;
  localparam int NV = 14;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, modeRoundRobin, modeTwoMiss, missValid, usefulValid, uselessValid, hitValid;
  logic [PCW-1:0] missPcWord, usefulPcWord, uselessPcWord;
  logic [1:0] hitBuf, allocBuf;
  logic [NB-1:0] reqVec, grantVec;
  logic allocValid;

  prefetch_alloc_sched #(.NUM_BUF(NB), .PC_W(PCW), .TBL_W(TW), .PRI_W(3),
                         .PRI_INIT(PINIT), .DECAY_PERIOD(DP)) u0 (
    .clk(clk), .rstN(rstN), .modeRoundRobin(modeRoundRobin), .modeTwoMiss(modeTwoMiss),
    .missValid(missValid), .missPcWord(missPcWord), .usefulValid(usefulValid),
    .usefulPcWord(usefulPcWord), .uselessValid(uselessValid), .uselessPcWord(uselessPcWord),
    .hitValid(hitValid), .hitBuf(hitBuf), .reqVec(reqVec),
    .allocValid(allocValid), .allocBuf(allocBuf), .grantVec(grantVec));

  // row: rr tm miss mIdx[4] uv uIdx[4] dv dIdx[4] hv hb[2] req[4]
  localparam logic [23:0] VEC [0:NV-1] = '{
    {1'b0,1'b0,1'b1,4'd1, 1'b0,4'd0, 1'b0,4'd0, 1'b0,2'd0, 4'b0000},
    {1'b0,1'b0,1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd2, 1'b1,2'd2, 4'b1111},
    {1'b0,1'b0,1'b1,4'd2, 1'b1,4'd3, 1'b1,4'd2, 1'b1,2'd2, 4'b0011},
    {1'b0,1'b0,1'b1,4'd2, 1'b0,4'd0, 1'b0,4'd0, 1'b1,2'd1, 4'b0110},
    {1'b0,1'b0,1'b0,4'd0, 1'b1,4'd3, 1'b1,4'd3, 1'b1,2'd3, 4'b1010},
    {1'b0,1'b0,1'b1,4'd3, 1'b1,4'd3, 1'b0,4'd0, 1'b0,2'd0, 4'b1100},
    {1'b1,1'b0,1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,2'd0, 4'b1111},
    {1'b1,1'b0,1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,2'd0, 4'b1111},
    {1'b1,1'b0,1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,2'd0, 4'b1001},
    {1'b1,1'b0,1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,2'd0, 4'b0100},
    {1'b1,1'b1,1'b1,4'd9, 1'b0,4'd0, 1'b0,4'd0, 1'b0,2'd0, 4'b0000},
    {1'b1,1'b1,1'b1,4'd9, 1'b0,4'd0, 1'b0,4'd0, 1'b1,2'd0, 4'b0001},
    {1'b0,1'b1,1'b1,4'd9, 1'b0,4'd0, 1'b0,4'd0, 1'b0,2'd0, 4'b1111},
    {1'b0,1'b0,1'b1,4'd9, 1'b0,4'd0, 1'b0,4'd0, 1'b0,2'd0, 4'b0000}
  };

  int nChecks = 0, nFails = 0;
  int accM [16];
  bit seenM [16];
  int prioM [NB];
  int rrM, decM;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int foldM(input logic [PCW-1:0] pc);
    int h = 0;
    for (int i = 0; i < PCW; i++) if (pc[i]) h = h ^ (1 << (i % TW));
    return h;
  endfunction

  task automatic modelReset();
    for (int e = 0; e < 16; e++) begin accM[e] = 2; seenM[e] = 1'b0; end
    for (int b = 0; b < NB; b++) prioM[b] = 0;
    rrM = 0; decM = 0;
  endtask

  task automatic idleInputs();
    modeRoundRobin = 0; modeTwoMiss = 0; missValid = 0; usefulValid = 0; uselessValid = 0;
    hitValid = 0; hitBuf = 0; reqVec = 0; missPcWord = 0; usefulPcWord = 0; uselessPcWord = 0;
  endtask

  // inputs are set after a falling edge; check, then take the rising edge
  task automatic step();
    int mi, ui, di, vic, win, expAlloc, expGrant, tick;
    #1;
    mi = foldM(missPcWord); ui = foldM(usefulPcWord); di = foldM(uselessPcWord);
    expAlloc = missValid && (modeTwoMiss ? int'(seenM[mi]) : int'(accM[mi] >= 2));
    vic = 0;
    for (int b = 1; b < NB; b++) if (prioM[b] < prioM[vic]) vic = b;
    win = -1;
    if (!modeRoundRobin) begin
      for (int b = 0; b < NB; b++) if (reqVec[b] && (win < 0 || prioM[b] > prioM[win])) win = b;
    end else begin
      for (int k = 0; k < NB; k++) if (win < 0 && reqVec[(rrM + k) % NB]) win = (rrM + k) % NB;
    end
    expGrant = (win < 0) ? 0 : (1 << win);
    chk(modeTwoMiss ? "R3" : "R2", "allocValid", int'(allocValid), expAlloc);
    if (!missValid) chk("R4", "allocValid without miss", int'(allocValid), 0);
    chk("R5", "allocBuf", int'(allocBuf), vic);
    chk(modeRoundRobin ? "R9" : "R8", "grantVec", int'(grantVec), expGrant);
    @(posedge clk);
    for (int e = 0; e < 16; e++) begin
      bit inc = usefulValid && ui == e;
      bit dec = uselessValid && di == e;
      if (inc && !dec && accM[e] < 3) accM[e]++;
      else if (dec && !inc && accM[e] > 0) accM[e]--;
    end
    if (modeTwoMiss && missValid) seenM[mi] = !seenM[mi];
    tick = (decM == DP - 1);
    decM = tick ? 0 : decM + 1;
    for (int b = 0; b < NB; b++) begin
      bit inc = hitValid && int'(hitBuf) == b;
      if (expAlloc != 0 && b == vic) prioM[b] = PINIT;
      else if (inc && !tick && prioM[b] < 7) prioM[b]++;
      else if (tick && !inc && prioM[b] > 0) prioM[b]--;
    end
    if (win >= 0) rrM = (win + 1) % NB;
    @(negedge clk);
  endtask

  task automatic applyVec(input logic [23:0] v);
    modeRoundRobin = v[23]; modeTwoMiss = v[22]; missValid = v[21];
    missPcWord = PCW'(v[20:17]); usefulValid = v[16]; usefulPcWord = PCW'(v[15:12]);
    uselessValid = v[11]; uselessPcWord = PCW'(v[10:7]); hitValid = v[6];
    hitBuf = v[5:4]; reqVec = v[3:0];
    step();
  endtask

  task automatic doReset();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    modelReset();
  endtask

  bit done = 0;

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    idleInputs();
    doReset();

    // reset state: victim 0, all ranks tie, pointer 0, confidence 2
    #1;
    chk("R5", "victim after reset", int'(allocBuf), 0);
    reqVec = 4'b0110;
    #1 chk("R8", "tie after reset picks lowest index", int'(grantVec), 4'b0010);
    missValid = 1; missPcWord = 30'h5;
    #1 chk("R1", "reset confidence permits allocation", int'(allocValid), 1);
    idleInputs();
    @(negedge clk);
    doReset();

    for (int i = 0; i < NV; i++) applyVec(VEC[i]);

    // R2: confidence driven to 0 blocks allocation; fold aliasing shares entries
    idleInputs();
    uselessValid = 1; uselessPcWord = 30'h6; step();
    uselessPcWord = 30'h60; step();   // folds to index 6 as well
    idleInputs(); missValid = 1; missPcWord = 30'h6;
    #1 chk("R2", "low-confidence load refused", int'(allocValid), 0);
    step();
    // R1: simultaneous useful and useless on one entry is neutral
    idleInputs(); usefulValid = 1; uselessValid = 1; usefulPcWord = 30'h6; uselessPcWord = 30'h6; step();
    idleInputs(); missValid = 1; missPcWord = 30'h6;
    #1 chk("R1", "useful+useless leaves entry", int'(allocValid), 0);
    step();

    // R3: second miss allocates, third does not
    idleInputs(); modeTwoMiss = 1; missValid = 1; missPcWord = 30'h7;
    #1 chk("R3", "first miss filtered", int'(allocValid), 0);
    step();
    #1 chk("R3", "second miss allocates", int'(allocValid), 1);
    step();
    #1 chk("R3", "third miss filtered again", int'(allocValid), 0);
    step();

    // R6: hammer buffer 2, it must win the ranked grant
    idleInputs();
    for (int k = 0; k < 10; k++) begin hitValid = 1; hitBuf = 2; step(); end
    idleInputs(); reqVec = 4'b1111;
    #1 chk("R6", "most hit buffer wins", int'(grantVec), 4'b0100);
    step();

    // R7: long idle lets decay drain every counter
    idleInputs();
    for (int k = 0; k < 8 * DP; k++) step();
    #1 chk("R7", "decay empties ranks, victim is 0", int'(allocBuf), 0);

    // mixed pseudo-random traffic in all mode combinations
    for (int k = 0; k < 4000; k++) begin
      modeRoundRobin = (k / 500) % 2;
      modeTwoMiss    = (k / 1000) % 2;
      missValid      = ($urandom % 3) == 0;
      missPcWord     = PCW'($urandom);
      usefulValid    = ($urandom % 2);
      usefulPcWord   = PCW'($urandom % 64);
      uselessValid   = ($urandom % 3) == 0;
      uselessPcWord  = PCW'($urandom % 64);
      hitValid       = ($urandom % 2);
      hitBuf         = 2'($urandom);
      reqVec         = 4'($urandom);
      step();
    end

    // reset in the middle of activity
    doReset();
    idleInputs(); modeRoundRobin = 1; reqVec = 4'b1000;
    #1 chk("R9", "pointer restarts at 0 after reset", int'(grantVec), 4'b1000);
    step();
    reqVec = 4'b1001;
    #1 chk("R9", "wrap to buffer 0 after 3", int'(grantVec), 4'b0001);
    step();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule